// File: doc/BRIEF.md
# Security-Banked Private Interrupt Register Bank

This block holds the per-interrupt configuration and state for 32 private interrupt lines of one processor. Software reaches it through a simple register bus that makes one access per cycle. An access is either a 32-bit word or, in the priority window only, a single byte. Every access carries a secure flag. When security is enabled (`sec_off` low), a non-secure access sees only the interrupts whose group bit is 1. Every other bit or priority byte reads as zero and does not change on a write.

The bank also watches the 32 interrupt input lines. A rising edge on a line configured as edge-triggered latches its pending bit. A level-triggered line shows as pending for as long as it is high. A one-cycle software request input sets the pending bit of one of the interrupts 0 to 15. Three vectors go to the prioritisation logic downstream: the effective pending vector, the enable vector and all 32 priority bytes.

Top module: `sec_irq_bank`

## Requirements
- R1: After reset, every stored register is zero and the edge history is zero. With all inputs low, `pend_vec`, `en_vec` and `prio_vec` are zero.
- R2: When `acc_secure`=0 and `sec_off`=0, the access mask is the group register at byte offset 0x00; otherwise the mask is all ones. In the masked case, a read of that offset returns 0 and a write to it is ignored. Secure writes, and any write while `sec_off`=1, load the group register.
- R3: Enable, pending and active each have a set offset and a clear offset: 0x04/0x08, 0x0C/0x10 and 0x14/0x18. A set write ORs in (data AND mask). A clear write clears (data AND mask). Both offsets read back (value AND mask).
- R4: A 0-to-1 change on `irq_line[i]`, compared with the value sampled on the previous clock, sets pending bit i on the next edge only if line i is edge-triggered. A line that stays high latches nothing more.
- R5: For every level-triggered line, the pending read value and `pend_vec` are the pending latch ORed with the line's current level.
- R6: Priority byte i is at offset 0x40+i. A byte access uses data bits [7:0]. A word access at 0x40+4n covers bytes 4n to 4n+3, with byte 4n+j on data bits [8j+7:8j]. Each byte obeys mask bit i independently.
- R7: The group-modifier word (0x28) and the non-secure access word (0x2C) are writable and readable only by a secure access while `sec_off`=0. Otherwise they read as 0 and ignore writes.
- R8: The configuration words are 0x20 for interrupts 0 to 15 and 0x24 for interrupts 16 to 31, with two bits per interrupt. Bit 2k+1 of a word is the edge bit of interrupt k of that half, and bit 2k reads 0. Interrupts 0 to 15 are always edge-triggered and cannot be written. Both reads and writes apply the mask.
- R9: With parameter `NMI_EN`=1, the word at 0x1C is a masked read/write register. With `NMI_EN`=0 it reads 0 and ignores writes.
- R10: `sgi_valid` sets pending bit `sgi_id` on the next edge, whatever the mask.
- R11: A byte access outside 0x40 to 0x5F, a word access with nonzero `acc_addr[1:0]`, or any other unlisted offset raises `acc_err` for that cycle. Such an access reads 0 and writes nothing. With `acc_valid`=0, `acc_rdata` is 0.
- R12: An edge latch or software request on a bit wins over a clear-pending write to the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_secure | input | 1 | Access is secure |
| acc_addr | input | 8 | Byte offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| acc_err | output | 1 | Decode error for this access |
| sec_off | input | 1 | Global security disable |
| irq_line | input | 32 | Interrupt input lines |
| sgi_valid | input | 1 | Software interrupt request |
| sgi_id | input | 4 | Software interrupt number |
| pend_vec | output | 32 | Effective pending vector |
| en_vec | output | 32 | Enable vector |
| prio_vec | output | 256 | Priority bytes, byte i at bits [8i+7:8i] |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that `acc_write` has meaning only while `acc_valid` is high, and that `sgi_id` is always within range. The bench drives every input just after the falling edge and keeps `irq_line` low through reset, so no edge is latched before the first access. The bench never drops `acc_valid` low while a write is pending.

// File: rtl/sec_irq_bank.sv
module sec_irq_bank #(
  parameter bit NMI_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_valid,
  input  logic         acc_write,
  input  logic         acc_byte,
  input  logic         acc_secure,
  input  logic [7:0]   acc_addr,
  input  logic [31:0]  acc_wdata,
  output logic [31:0]  acc_rdata,
  output logic         acc_err,
  input  logic         sec_off,
  input  logic [31:0]  irq_line,
  input  logic         sgi_valid,
  input  logic [3:0]   sgi_id,
  output logic [31:0]  pend_vec,
  output logic [31:0]  en_vec,
  output logic [255:0] prio_vec
);
  localparam int N = 32;
  localparam logic [7:0] A_GRP = 8'h00, A_ENS = 8'h04, A_ENC = 8'h08,
    A_PDS = 8'h0C, A_PDC = 8'h10, A_ACS = 8'h14, A_ACC = 8'h18, A_NMI = 8'h1C,
    A_CFL = 8'h20, A_CFH = 8'h24, A_GMD = 8'h28, A_NSC = 8'h2C;

  logic [31:0] grp, en, pend, act, nmi, gmod, nsac, lvl_q;
  logic [15:0] edge_hi;
  logic [7:0]  prio [N];

  wire         ns_lim   = !acc_secure && !sec_off;
  wire         sec_only = acc_secure && !sec_off;
  wire  [31:0] amask    = ns_lim ? grp : 32'hFFFF_FFFF;
  wire  [31:0] edge_all = {edge_hi, 16'hFFFF};
  wire  [31:0] pend_eff = pend | (~edge_all & irq_line);
  wire  [31:0] rise     = irq_line & ~lvl_q & edge_all;
  wire         in_prio  = acc_addr[7:5] == 3'b010;
  wire         aligned  = acc_byte ? in_prio : (acc_addr[1:0] == 2'b00);
  wire         wr       = acc_valid && acc_write && !acc_err;

  logic [31:0] rd, odd_bits, set_w, clr_w, pend_nxt;
  logic        known;
  logic [4:0]  idx;

  always_comb begin
    for (int k = 0; k < 16; k++) odd_bits[k] = acc_wdata[2*k+1];
    odd_bits[31:16] = '0;
  end

  always_comb begin
    rd = '0;
    known = 1'b1;
    idx = '0;
    if (in_prio) begin
      if (acc_byte) begin
        idx = acc_addr[4:0];
        rd[7:0] = amask[idx] ? prio[idx] : 8'h00;
      end else begin
        for (int j = 0; j < 4; j++) begin
          idx = {acc_addr[4:2], 2'(j)};
          rd[8*j +: 8] = amask[idx] ? prio[idx] : 8'h00;
        end
      end
    end else begin
      case (acc_addr)
        A_GRP:        rd = ns_lim ? '0 : grp;
        A_ENS, A_ENC: rd = en & amask;
        A_PDS, A_PDC: rd = pend_eff & amask;
        A_ACS, A_ACC: rd = act & amask;
        A_NMI:        rd = NMI_EN ? (nmi & amask) : '0;
        A_CFL:        for (int k = 0; k < 16; k++) rd[2*k+1] = amask[k];
        A_CFH:        for (int k = 0; k < 16; k++) rd[2*k+1] = edge_hi[k] & amask[16+k];
        A_GMD:        rd = sec_only ? gmod : '0;
        A_NSC:        rd = sec_only ? nsac : '0;
        default:      known = 1'b0;
      endcase
    end
  end

  assign acc_err   = acc_valid && (!aligned || !known);
  assign acc_rdata = (acc_valid && !acc_err) ? rd : '0;

  assign set_w    = (wr && acc_addr == A_PDS) ? (acc_wdata & amask) : '0;
  assign clr_w    = (wr && acc_addr == A_PDC) ? (acc_wdata & amask) : '0;
  assign pend_nxt = (pend & ~clr_w) | set_w | rise | (sgi_valid ? (32'd1 << sgi_id) : 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {grp, en, pend, act, nmi, gmod, nsac, lvl_q} <= '0;
      edge_hi <= '0;
      for (int i = 0; i < N; i++) prio[i] <= '0;
    end else begin
      lvl_q <= irq_line;
      pend  <= pend_nxt;
      if (wr && in_prio) begin
        if (acc_byte) begin
          if (amask[acc_addr[4:0]]) prio[acc_addr[4:0]] <= acc_wdata[7:0];
        end else begin
          for (int j = 0; j < 4; j++)
            if (amask[{acc_addr[4:2], 2'(j)}]) prio[{acc_addr[4:2], 2'(j)}] <= acc_wdata[8*j +: 8];
        end
      end else if (wr) begin
        case (acc_addr)
          A_GRP: if (!ns_lim) grp <= acc_wdata;
          A_ENS: en  <= en | (acc_wdata & amask);
          A_ENC: en  <= en & ~(acc_wdata & amask);
          A_ACS: act <= act | (acc_wdata & amask);
          A_ACC: act <= act & ~(acc_wdata & amask);
          A_NMI: if (NMI_EN) nmi <= (nmi & ~amask) | (acc_wdata & amask);
          A_CFH: edge_hi <= (edge_hi & ~amask[31:16]) | (odd_bits[15:0] & amask[31:16]);
          A_GMD: if (sec_only) gmod <= acc_wdata;
          A_NSC: if (sec_only) nsac <= acc_wdata;
          default: ;
        endcase
      end
    end
  end

  assign pend_vec = pend_eff;
  assign en_vec   = en;
  for (genvar g = 0; g < N; g++) begin : g_prio
    assign prio_vec[8*g +: 8] = prio[g];
  end

  assert_grp_wi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_byte && acc_addr == A_GRP && !acc_secure && !sec_off) |=> $stable(grp));

  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 32'd0) |=> ((pend & $past(rise)) == $past(rise)));

  assert_secure_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (acc_addr == A_GMD || acc_addr == A_NSC) && !(acc_secure && !sec_off))
      |=> ($stable(gmod) && $stable(nsac)));

  assert_nmi_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!NMI_EN && acc_valid && acc_addr == A_NMI) |-> (acc_rdata == 32'd0));

  assert_sgi_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sgi_valid |=> pend[$past(sgi_id)]);

  assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_valid && acc_rdata == 32'd0));
endmodule

// File: tb/test_sec_irq_bank.sv
module test_sec_irq_bank;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, acc_valid = 0, acc_write = 0, acc_byte = 0, acc_secure = 0;
  logic [7:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, irq_line = '0;
  logic sec_off = 0, sgi_valid = 0;
  logic [3:0] sgi_id = '0;
  logic [31:0] acc_rdata, pend_vec, en_vec, rdata2, pv2, ev2;
  logic acc_err, err2;
  logic [255:0] prio_vec, prv2;

  sec_irq_bank i_sec_irq_bank (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_byte(acc_byte), .acc_secure(acc_secure), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err), .sec_off(sec_off), .irq_line(irq_line),
    .sgi_valid(sgi_valid), .sgi_id(sgi_id), .pend_vec(pend_vec), .en_vec(en_vec), .prio_vec(prio_vec));

  sec_irq_bank #(.NMI_EN(1'b0)) i_sec_irq_bank_nonmi (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_byte(acc_byte), .acc_secure(acc_secure), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(rdata2), .acc_err(err2), .sec_off(sec_off), .irq_line(irq_line),
    .sgi_valid(sgi_valid), .sgi_id(sgi_id), .pend_vec(pv2), .en_vec(ev2), .prio_vec(prv2));

  int total = 0, bad = 0;
  string req = "R1";

  // behavioural reference state
  bit [31:0] m_grp, m_en, m_pend, m_act, m_nmi, m_gmod, m_nsac, m_prev;
  bit [15:0] m_edge;
  bit [7:0]  m_prio [32];

  function automatic bit is_edge(int i);
    return (i < 16) ? 1'b1 : m_edge[i-16];
  endfunction

  function automatic bit [31:0] eff_pend();
    bit [31:0] r = m_pend;
    for (int i = 0; i < 32; i++) if (!is_edge(i) && irq_line[i]) r[i] = 1'b1;
    return r;
  endfunction

  function automatic bit [31:0] vis();
    if (!acc_secure && !sec_off) return m_grp;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic void m_read(output bit [31:0] d, output bit e);
    bit [31:0] v = vis();
    bit priv = acc_secure && !sec_off;
    int a = acc_addr;
    d = 0; e = 0;
    if (!acc_valid) return;
    if (a >= 'h40 && a < 'h60) begin
      if (acc_byte) d[7:0] = v[a-'h40] ? m_prio[a-'h40] : 8'h00;
      else if (a % 4 != 0) e = 1;
      else for (int j = 0; j < 4; j++) d[8*j +: 8] = v[a-'h40+j] ? m_prio[a-'h40+j] : 8'h00;
    end else if (acc_byte || a % 4 != 0) e = 1;
    else begin
      case (a)
        'h00: d = (!acc_secure && !sec_off) ? 0 : m_grp;
        'h04, 'h08: d = m_en & v;
        'h0C, 'h10: d = eff_pend() & v;
        'h14, 'h18: d = m_act & v;
        'h1C: d = m_nmi & v;
        'h20: for (int k = 0; k < 16; k++) d[2*k+1] = v[k];
        'h24: for (int k = 0; k < 16; k++) d[2*k+1] = m_edge[k] & v[16+k];
        'h28: d = priv ? m_gmod : 0;
        'h2C: d = priv ? m_nsac : 0;
        default: e = 1;
      endcase
    end
    if (e) d = 0;
  endfunction

  function automatic void m_step();
    bit [31:0] d, v, np;
    bit e, priv;
    int a;
    if (!rst_n) begin
      m_grp = 0; m_en = 0; m_pend = 0; m_act = 0; m_nmi = 0; m_gmod = 0; m_nsac = 0;
      m_prev = 0; m_edge = 0;
      for (int i = 0; i < 32; i++) m_prio[i] = 0;
      return;
    end
    m_read(d, e);
    v = vis(); priv = acc_secure && !sec_off; a = acc_addr;
    np = m_pend;
    if (acc_valid && acc_write && !e) begin
      if (a >= 'h40 && a < 'h60) begin
        if (acc_byte) begin if (v[a-'h40]) m_prio[a-'h40] = acc_wdata[7:0]; end
        else for (int j = 0; j < 4; j++) if (v[a-'h40+j]) m_prio[a-'h40+j] = acc_wdata[8*j +: 8];
      end else case (a)
        'h00: if (!(!acc_secure && !sec_off)) m_grp = acc_wdata;
        'h04: m_en |= acc_wdata & v;
        'h08: m_en &= ~(acc_wdata & v);
        'h0C: np |= acc_wdata & v;
        'h10: np &= ~(acc_wdata & v);
        'h14: m_act |= acc_wdata & v;
        'h18: m_act &= ~(acc_wdata & v);
        'h1C: m_nmi = (m_nmi & ~v) | (acc_wdata & v);
        'h24: for (int k = 0; k < 16; k++) if (v[16+k]) m_edge[k] = acc_wdata[2*k+1];
        'h28: if (priv) m_gmod = acc_wdata;
        'h2C: if (priv) m_nsac = acc_wdata;
        default: ;
      endcase
    end
    for (int i = 0; i < 32; i++) if (irq_line[i] && !m_prev[i] && is_edge_old(i)) np[i] = 1'b1;
    if (sgi_valid) np[sgi_id] = 1'b1;
    m_pend = np;
    m_prev = irq_line;
  endfunction

  // edge configuration as it stood before this cycle's write
  bit [15:0] edge_before;
  function automatic bit is_edge_old(int i);
    return (i < 16) ? 1'b1 : edge_before[i-16];
  endfunction

  task automatic chk(string what, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit [31:0] d; bit e; logic [255:0] pe;
    @(negedge clk);
    edge_before = m_edge;
    m_step();
    m_read(d, e);
    for (int i = 0; i < 32; i++) pe[8*i +: 8] = m_prio[i];
    chk("rdata", {224'd0, acc_rdata}, {224'd0, d});
    chk("err", {255'd0, acc_err}, {255'd0, e});
    chk("pend_vec", {224'd0, pend_vec}, {224'd0, eff_pend()});
    chk("en_vec", {224'd0, en_vec}, {224'd0, m_en});
    chk("prio_vec", prio_vec, pe);
  endtask

  task automatic acc(bit w, bit b, bit s, logic [7:0] a, logic [31:0] d);
    acc_valid = 1; acc_write = w; acc_byte = b; acc_secure = s; acc_addr = a; acc_wdata = d;
    tick();
    acc_valid = 0; acc_write = 0; acc_byte = 0;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req = "R1"; tick(); tick(); rst_n = 1; tick(); tick();
    acc(0, 0, 1, 8'h04, 0); acc(0, 0, 1, 8'h00, 0);
    // R2: group mask
    req = "R2";
    acc(1, 0, 1, 8'h00, 32'hFFFF_0000);
    acc(1, 0, 0, 8'h00, 32'h0000_0000);
    acc(0, 0, 0, 8'h00, 0);
    acc(0, 0, 1, 8'h00, 0);
    // R3: set/clear aliases with mask
    req = "R3";
    acc(1, 0, 1, 8'h04, 32'hF0F0_F0F0);
    acc(1, 0, 0, 8'h08, 32'hFFFF_FFFF);
    acc(0, 0, 0, 8'h04, 0); acc(0, 0, 1, 8'h08, 0);
    acc(1, 0, 0, 8'h04, 32'h0000_FFFF);
    acc(1, 0, 1, 8'h0C, 32'h0001_0002); acc(1, 0, 0, 8'h10, 32'hFFFF_FFFF);
    acc(0, 0, 0, 8'h0C, 0); acc(0, 0, 1, 8'h10, 0);
    acc(1, 0, 1, 8'h14, 32'h8000_0001); acc(1, 0, 1, 8'h18, 32'h0000_0001);
    acc(0, 0, 1, 8'h14, 0); acc(0, 0, 0, 8'h18, 0);
    acc(1, 0, 1, 8'h10, 32'hFFFF_FFFF);
    // R8: configuration, lines 16..23 edge
    req = "R8";
    acc(1, 0, 1, 8'h24, 32'h0000_AAAA);
    acc(1, 0, 1, 8'h20, 32'h0000_0000);
    acc(0, 0, 1, 8'h20, 0); acc(0, 0, 0, 8'h20, 0); acc(0, 0, 1, 8'h24, 0);
    acc(0, 0, 0, 8'h24, 0);
    // R4: edge latch only on edge-configured lines
    req = "R4";
    irq_line = 32'h0202_0008; tick(); tick();
    acc(0, 0, 1, 8'h0C, 0);
    irq_line = 0; tick();
    acc(0, 0, 1, 8'h0C, 0);
    acc(1, 0, 1, 8'h10, 32'hFFFF_FFFF);
    irq_line = 32'h0002_0000; tick(); irq_line = 0; tick(); irq_line = 32'h0002_0000; tick();
    // R5: level line merged into pending
    req = "R5";
    irq_line = 32'h0200_0000; tick();
    acc(1, 0, 1, 8'h10, 32'h0200_0000);
    acc(0, 0, 0, 8'h0C, 0);
    irq_line = 0; tick(); acc(0, 0, 1, 8'h0C, 0);
    // R6: priority bytes
    req = "R6";
    acc(1, 0, 1, 8'h44, 32'h4433_2211);
    acc(1, 1, 0, 8'h41, 32'h0000_00EE);
    acc(1, 1, 0, 8'h51, 32'h0000_00CC);
    acc(1, 0, 0, 8'h5C, 32'hA1B2_C3D4);
    acc(1, 0, 0, 8'h40, 32'h9999_9999);
    acc(0, 0, 0, 8'h50, 0); acc(0, 0, 1, 8'h44, 0); acc(0, 1, 0, 8'h45, 0); acc(0, 1, 1, 8'h45, 0);
    // R7: secure-only words
    req = "R7";
    acc(1, 0, 1, 8'h28, 32'h1234_5678); acc(1, 0, 1, 8'h2C, 32'hCAFE_0001);
    acc(1, 0, 0, 8'h28, 32'h0); acc(1, 0, 0, 8'h2C, 32'h0);
    acc(0, 0, 1, 8'h28, 0); acc(0, 0, 0, 8'h2C, 0);
    sec_off = 1;
    acc(1, 0, 1, 8'h28, 32'h0); acc(0, 0, 1, 8'h28, 0); acc(0, 0, 1, 8'h2C, 0);
    req = "R2"; acc(1, 0, 0, 8'h00, 32'h0000_00FF); acc(0, 0, 0, 8'h00, 0); acc(0, 0, 0, 8'h04, 0);
    acc(1, 0, 0, 8'h00, 32'hFFFF_0000);
    sec_off = 0; acc(0, 0, 1, 8'h28, 0);
    // R9: non-maskable word in both variants
    req = "R9";
    acc(1, 0, 1, 8'h1C, 32'h0000_F00F); acc(1, 0, 0, 8'h1C, 32'hFFFF_FFFF);
    acc_valid = 1; acc_addr = 8'h1C; acc_secure = 1; tick();
    chk("nonmi rdata", {224'd0, rdata2}, 256'd0);
    acc_valid = 0;
    // R10: software request
    req = "R10";
    sgi_valid = 1; sgi_id = 4'd5; tick(); sgi_valid = 0; tick();
    acc(0, 0, 0, 8'h0C, 0);
    // R11: decode errors
    req = "R11";
    acc(0, 0, 1, 8'h30, 0); acc(1, 0, 1, 8'h30, 32'hFFFF_FFFF);
    acc(1, 1, 1, 8'h04, 32'hFF); acc(0, 1, 1, 8'h04, 0);
    acc(1, 0, 1, 8'h42, 32'hFFFF_FFFF); acc(0, 0, 1, 8'h06, 0); acc(0, 0, 1, 8'h04, 0);
    // R12: set sources beat a clear write
    req = "R12";
    irq_line = 0; tick();
    acc_valid = 1; acc_write = 1; acc_secure = 1; acc_addr = 8'h10; acc_wdata = 32'hFFFF_FFFF;
    irq_line = 32'h0004_0000; sgi_valid = 1; sgi_id = 4'd6;
    tick();
    acc_valid = 0; acc_write = 0; sgi_valid = 0;
    acc(0, 0, 1, 8'h0C, 0);
    irq_line = 0; tick(); tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule